// File: doc/BRIEF.md
# Bounded Case Dispatch Unit

This unit carries out a table-driven multiway branch. Once a start pulse arrives it takes a selector, a base, a limit, an opcode and the address of a table of 16-bit signed displacements. The opcode sets the operand size. The unit subtracts the base from the selector at that size to form a zero-origin index. It then compares the index with the limit, treating both as unsigned.

When the index is inside the table, the unit reads one table entry through a plain read port. The port has a request, an address, a valid and 16 data bits. The unit sign-extends the entry and adds it to the table address to produce the next program counter. When the index is outside the table, the unit issues no read. Instead it returns the address just past the table, one cycle after the start.

On both paths the unit reports condition flags taken from the index-versus-limit comparison. Instruction decode and operand fetch happen upstream. The result is read from `next_pc` and the flags during the cycle in which `done` is high.

Top module: `case_dispatch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `mem_req`, `next_pc` and all four flags are cleared.
- R2: Opcode 8'h8F selects byte size, which uses operand bits [7:0]. Opcode 8'hAF selects word size, which uses bits [15:0]. Opcode 8'hCF, and every other code, selects longword size, which uses bits [31:0]. Operand bits above the selected size have no effect.
- R3: The index is (selector − base) modulo 2^size, zero-extended. The index is in range exactly when it is ≤ limit, with the limit truncated to the same size and compared unsigned.
- R4: For an in-range index, `mem_req` rises one cycle after the start. `mem_addr` equals table_pc + 2 × index. Both hold steady until `mem_valid` is sampled high.
- R5: The clock edge that samples `mem_valid` high during a request drops `mem_req` and raises `done`. At the same edge, `next_pc` becomes table_pc + the 16-bit `mem_data`, sign-extended to 32 bits.
- R6: For an out-of-range index, no request is made. `done` rises one cycle after the start, and `next_pc` equals table_pc + 2 × (limit + 1), modulo 2^32.
- R7: `flag_n` = index < limit, compared signed at the operand size. `flag_z` = index equals limit. `flag_c` = index < limit, compared unsigned. `flag_v` = 0. The same rule applies on both paths, and the flags are valid while `done` is high.
- R8: `done` is high for exactly one cycle for each operation. A start that arrives while a request is open is ignored. A `mem_valid` that arrives while no request is open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation with the operands below |
| opcode | input | 8 | Size select code |
| sel_val | input | 32 | Selector operand |
| base_val | input | 32 | Base operand |
| lim_val | input | 32 | Limit operand |
| table_pc | input | 32 | Address of the first displacement entry |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 16 | Read data (signed displacement) |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 32 | Resulting program counter |
| flag_n | output | 1 | Signed less-than flag |
| flag_z | output | 1 | Equal flag |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_c | output | 1 | Unsigned less-than flag |

## Verification
An out-of-range operation shows `done`, `next_pc` and the flags at the first falling edge after the rising edge that sampled the start. An in-range operation shows `mem_req` and `mem_addr` at that same falling edge. Its result appears at the falling edge after the rising edge that sampled `mem_valid`. The bench drives every input on a falling edge and reads each result exactly at its due falling edge. It also inserts zero to two cycles of read latency, during which it confirms that the request is held. One falling edge later it confirms that `done` has fallen again.

// File: rtl/cd_pkg.sv
// Shared definitions for the case dispatch unit: operand size codes,
// the opcode-to-size decode and the size-dependent extension helpers.
// Assumes a 32-bit datapath and 16-bit table entries.
package cd_pkg;
    localparam int WORD_W = 32;
    localparam int DISP_W = 16;

    typedef enum logic [1:0] {SZ_BYTE, SZ_WORD, SZ_LONG} opsize_e;

    localparam logic [7:0] OPC_BYTE = 8'h8F;
    localparam logic [7:0] OPC_WORD = 8'hAF;
    localparam logic [7:0] OPC_LONG = 8'hCF;

    // Map an opcode to its operand size; unknown codes fall back to longword.
    function automatic opsize_e decode_size(input logic [7:0] opc);
        case (opc)
            OPC_BYTE: decode_size = SZ_BYTE;
            OPC_WORD: decode_size = SZ_WORD;
            default:  decode_size = SZ_LONG;
        endcase
    endfunction

    // Keep only the bits of the given size, zero above.
    function automatic logic [WORD_W-1:0] zext_sz(input logic [WORD_W-1:0] v, input opsize_e s);
        case (s)
            SZ_BYTE: zext_sz = {{(WORD_W-8){1'b0}}, v[7:0]};
            SZ_WORD: zext_sz = {{(WORD_W-16){1'b0}}, v[15:0]};
            default: zext_sz = v;
        endcase
    endfunction

    // Keep only the bits of the given size, sign-extended above.
    function automatic logic [WORD_W-1:0] sext_sz(input logic [WORD_W-1:0] v, input opsize_e s);
        case (s)
            SZ_BYTE: sext_sz = {{(WORD_W-8){v[7]}}, v[7:0]};
            SZ_WORD: sext_sz = {{(WORD_W-16){v[15]}}, v[15:0]};
            default: sext_sz = v;
        endcase
    endfunction
endpackage

// File: rtl/cd_operand_unit.sv
// Forms the zero-origin index (selector - base) at the operand size, the
// size-truncated limit, the in-range decision and the comparison flags.
// Purely combinational; assumes operands are stable while start is high.
module cd_operand_unit
    import cd_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  opsize_e        size,
    input  logic [W-1:0]   sel_val,
    input  logic [W-1:0]   base_val,
    input  logic [W-1:0]   lim_val,
    output logic [W-1:0]   idx_z,
    output logic [W-1:0]   lim_z,
    output logic           in_range,
    output logic           lt_signed,
    output logic           eq,
    output logic           lt_unsigned
);
    logic [W-1:0] diff;
    logic [W-1:0] idx_s;
    logic [W-1:0] lim_s;

    // Subtract and fold both index and limit to the operand size.
    always_comb begin
        diff        = sel_val - base_val;
        idx_z       = zext_sz(diff, size);
        lim_z       = zext_sz(lim_val, size);
        idx_s       = sext_sz(diff, size);
        lim_s       = sext_sz(lim_val, size);
        lt_unsigned = idx_z < lim_z;
        eq          = idx_z == lim_z;
        lt_signed   = $signed(idx_s) < $signed(lim_s);
        in_range    = lt_unsigned || eq;
    end
endmodule

// File: rtl/cd_target_calc.sv
// Address arithmetic: table entry address, skip-past-table target and the
// taken target from a fetched displacement. Combinational; entries are
// two bytes wide so indices scale by two.
module cd_target_calc #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] pc_live,
    input  logic [ADDR_W-1:0] pc_held,
    input  logic [ADDR_W-1:0] idx_z,
    input  logic [ADDR_W-1:0] lim_z,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] skip_pc,
    output logic [ADDR_W-1:0] taken_pc
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] lim_p1;

    // Compute the three candidate addresses.
    always_comb begin
        disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
        lim_p1     = lim_z + {{(ADDR_W-1){1'b0}}, 1'b1};
        fetch_addr = pc_live + {idx_z[ADDR_W-2:0], 1'b0};
        skip_pc    = pc_live + {lim_p1[ADDR_W-2:0], 1'b0};
        taken_pc   = pc_held + disp_ext;
    end
endmodule

// File: rtl/cd_sequencer.sv
// Two-state control: accepts a start while idle, either completes at once
// (out of range) or opens a table read and completes when data is valid.
// Holds flags and the result until the next accepted start.
module cd_sequencer #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_range,
    input  logic [2:0]        flags_new,
    input  logic [ADDR_W-1:0] pc_live,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] skip_pc,
    input  logic [ADDR_W-1:0] taken_pc,
    input  logic              mem_valid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] pc_held,
    output logic              done,
    output logic [ADDR_W-1:0] next_pc,
    output logic [2:0]        flags_q
);
    typedef enum logic {ST_IDLE, ST_FETCH} state_e;
    state_e state;

    // Request is open exactly while waiting for table data.
    assign mem_req = (state == ST_FETCH);

    // State, captured operands and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mem_addr <= '0;
            pc_held  <= '0;
            done     <= 1'b0;
            next_pc  <= '0;
            flags_q  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        flags_q <= flags_new;
                        if (in_range) begin
                            state    <= ST_FETCH;
                            mem_addr <= fetch_addr;
                            pc_held  <= pc_live;
                        end else begin
                            done    <= 1'b1;
                            next_pc <= skip_pc;
                        end
                    end
                end
                default: begin
                    if (mem_valid) begin
                        state   <= ST_IDLE;
                        done    <= 1'b1;
                        next_pc <= taken_pc;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/case_dispatch.sv
// Top of the bounded case dispatch unit. Decodes the operand size,
// forms the index and flags, and sequences either a single table read
// or a skip past the table. Assumes the read port answers eventually.
module case_dispatch
    import cd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [WORD_W-1:0] sel_val,
    input  logic [WORD_W-1:0] base_val,
    input  logic [WORD_W-1:0] lim_val,
    input  logic [WORD_W-1:0] table_pc,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DISP_W-1:0] mem_data,
    output logic              done,
    output logic [WORD_W-1:0] next_pc,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    opsize_e           size;
    logic [WORD_W-1:0] idx_z, lim_z, fetch_addr, skip_pc, taken_pc, pc_held;
    logic              in_range, lt_s, eq, lt_u;
    logic [2:0]        flags_q;

    // Operand size from the opcode.
    assign size = decode_size(opcode);

    cd_operand_unit #(.W(WORD_W)) u_opnd (
        .size(size), .sel_val(sel_val), .base_val(base_val), .lim_val(lim_val),
        .idx_z(idx_z), .lim_z(lim_z), .in_range(in_range),
        .lt_signed(lt_s), .eq(eq), .lt_unsigned(lt_u)
    );

    cd_target_calc #(.ADDR_W(WORD_W), .DISP_W(DISP_W)) u_tgt (
        .pc_live(table_pc), .pc_held(pc_held), .idx_z(idx_z), .lim_z(lim_z),
        .disp(mem_data), .fetch_addr(fetch_addr), .skip_pc(skip_pc), .taken_pc(taken_pc)
    );

    cd_sequencer #(.ADDR_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .in_range(in_range),
        .flags_new({lt_s, eq, lt_u}), .pc_live(table_pc),
        .fetch_addr(fetch_addr), .skip_pc(skip_pc), .taken_pc(taken_pc),
        .mem_valid(mem_valid), .mem_req(mem_req), .mem_addr(mem_addr),
        .pc_held(pc_held), .done(done), .next_pc(next_pc), .flags_q(flags_q)
    );

    // Flag outputs; overflow is never set by this operation.
    assign flag_n = flags_q[2];
    assign flag_z = flags_q[1];
    assign flag_c = flags_q[0];
    assign flag_v = 1'b0;
endmodule

// File: rtl/cd_checker.sv
// Port-level temporal checks for case_dispatch, attached by bind.
module cd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        done,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req); // R4
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> $stable(mem_addr)); // R4
    AST_DONE_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid |=> done && !mem_req); // R5
    AST_NO_REQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R6
    AST_SKIP_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && !$past(mem_req) |-> $past(start)); // R6
    AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_v); // R7
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(flag_z && (flag_n || flag_c))); // R7
endmodule

bind case_dispatch cd_checker u_cd_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .done(done),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/case_dispatch_bench.sv
module case_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h8F;
    logic [31:0] sel_val = '0, base_val = '0, lim_val = '0, table_pc = '0;
    logic        mem_req, mem_valid = 1'b0;
    logic [31:0] mem_addr, next_pc;
    logic [15:0] mem_data = '0;
    logic        done, flag_n, flag_z, flag_v, flag_c;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    case_dispatch u_case_dispatch (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .sel_val(sel_val), .base_val(base_val), .lim_val(lim_val), .table_pc(table_pc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
        .done(done), .next_pc(next_pc),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] msk(input logic [7:0] opc);
        return (opc == 8'h8F) ? 32'hFF : (opc == 8'hAF) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] sx(input logic [31:0] v, input logic [7:0] opc);
        if (opc == 8'h8F) return {{24{v[7]}}, v[7:0]};
        if (opc == 8'hAF) return {{16{v[15]}}, v[15:0]};
        return v;
    endfunction

    function automatic logic [15:0] mem_model(input logic [31:0] a);
        return a[16:1] ^ 16'hC3A5;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One operation, with read latency lat and an optional ignored start.
    task automatic run_op(input logic [7:0] opc, input logic [31:0] s, b, l, p,
                          input int lat, input bit poke);
        logic [31:0] m, t, lm, exp_pc;
        logic [15:0] d;
        bit inr, en, ez, ec;
        m  = msk(opc);
        t  = (s - b) & m;
        lm = l & m;
        inr = (t <= lm);
        en = $signed(sx(t, opc)) < $signed(sx(lm, opc));
        ez = (t == lm);
        ec = (t < lm);
        @(negedge clk);
        start = 1'b1; opcode = opc; sel_val = s; base_val = b; lim_val = l; table_pc = p;
        @(negedge clk);
        start = 1'b0;
        if (!inr) begin
            exp_pc = p + ((lm + 32'd1) << 1);
            chk(done == 1'b1, "R6 done", {31'd0, done}, 32'd1);
            chk(mem_req == 1'b0, "R6 no request", {31'd0, mem_req}, 32'd0);
            chk(next_pc == exp_pc, "R6 skip pc", next_pc, exp_pc);
        end else begin
            chk(mem_req == 1'b1 && done == 1'b0, "R4 request", {30'd0, mem_req, done}, 32'd2);
            chk(mem_addr == p + (t << 1), "R4 address R3 index", mem_addr, p + (t << 1));
            if (poke) begin
                start = 1'b1; sel_val = s + 32'd1; table_pc = p + 32'h100; opcode = 8'hCF;
            end
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                start = 1'b0;
                chk(mem_req && !done && mem_addr == p + (t << 1), "R4 hold", mem_addr, p + (t << 1));
            end
            d = mem_model(p + (t << 1));
            mem_valid = 1'b1; mem_data = d;
            @(negedge clk);
            mem_valid = 1'b0; start = 1'b0;
            exp_pc = p + {{16{d[15]}}, d};
            chk(done == 1'b1 && mem_req == 1'b0, "R5 done", {30'd0, done, mem_req}, 32'd2);
            chk(next_pc == exp_pc, "R5 taken pc R8 poke ignored", next_pc, exp_pc);
        end
        chk({flag_n, flag_z, flag_v, flag_c} == {en, ez, 1'b0, ec}, "R7 flags",
            {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, en, ez, 1'b0, ec});
        @(negedge clk);
        chk(done == 1'b0, "R8 single pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        logic [31:0] wv [6] = '{32'h0, 32'h1, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h1234_8001};
        logic [31:0] lv [6] = '{32'h0, 32'h3, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h10};
        int n = 0;
        repeat (3) @(negedge clk);
        chk(done == 0 && mem_req == 0 && next_pc == 0 && {flag_n, flag_z, flag_v, flag_c} == 0,
            "R1 reset", next_pc, 32'd0);
        rst_n = 1'b1;
        // R8: stray valid while idle
        @(negedge clk); mem_valid = 1'b1; mem_data = 16'h1234;
        @(negedge clk); mem_valid = 1'b0;
        chk(done == 0 && mem_req == 0, "R8 stray valid", {30'd0, done, mem_req}, 32'd0);
        // R2 R3 byte sweep with garbage upper bits
        for (int l = 0; l < 256; l += 15) begin
            for (int s = 0; s < 256; s += 13) begin
                run_op(8'h8F, 32'hA5C3_0000 | s, 32'h7E00_0003, 32'h5500_0000 | l,
                       32'h0000_4000 + n * 4, n % 3, (n % 7) == 0);
                n++;
            end
        end
        // R2 word and longword corners
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                for (int k = 0; k < 2; k++) begin
                    run_op(8'hAF, wv[i] ^ 32'hBEEF_0000, k ? 32'hFFFF : 32'h0, wv[j],
                           32'h8000_0000 - n, n % 3, (n % 5) == 0);
                    n++;
                    run_op((k == 0) ? 8'hCF : 8'h00, lv[i], k ? lv[j] : 32'h0, lv[j],
                           32'hFFFF_F000 + n * 2, n % 3, 1'b0);
                    n++;
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule